// File: doc/BRIEF.md
# Resident Translation Table

This block is the second level of address translation for one processor. It holds, in on-chip storage, the full set of virtual-to-physical page mappings for the application that is running. It is not a cache of a larger table in memory. When the operating layer switches applications, it flushes the table and then writes the next application's mappings into it, one entry at a time. A lookup therefore either finds its page or reports a miss. There is no refill from memory and no page-fault path.

Two first-level translation buffers send their misses here, one on the instruction side and one on the data side. A request carries a virtual page number counted in 1 KB units. The table checks every valid entry against it and answers with a found flag, the stored physical page number and the stored size code. Entries may describe pages of 1 KB times any power of four, up to 16 MB.

The search reads the entries four at a time and always runs over all 64 of them, so it takes 16 cycles whatever the outcome. With fixed priority to the instruction side, a data request that arrives in the same cycle is still answered 32 cycles after it was sampled.

Top module: `pgtab_top`

## Requirements
- R1: After reset neither side sees a response pulse, and all 64 entries are invalid, so every lookup misses.
- R2: Software writes through `sw_sel`/`sw_wdata` with `sw_wr`. The select codes are:
  - 0 = index, in bits [5:0].
  - 1 = tag word: virtual page number in bits [31:10], size code in bits [3:1], valid in bit [0].
  - 2 = data word: physical page number in bits [31:10].
  - 3 = command: bit 0 commits the staged entry, bit 1 flushes the table.
  A commit stores the staged tag and data at the staged index. A later lookup of that page returns found=1 with the stored physical page number and size code.
- R3: Size code s (0..7) describes a page of 1 KB times 4^s. Matching ignores the lowest 2*s bits of the virtual page number. A key that differs from the entry in any higher bit misses.
- R4: An entry whose valid bit is 0 never matches. A miss reports found=0, physical page 0 and size 0.
- R5: When several valid entries match, the one with the lowest index supplies the answer.
- R6: Latency is fixed and independent of which entry matches. On an idle table the response pulse follows exactly 16 clock edges after the edge that sampled the request. When both sides request on the same edge, the instruction side answers after 16 edges and the data side after 32.
- R7: A flush command invalidates every entry at once.
- R8: A commit or flush that arrives while a search is running is held and applied on the search's final edge. The search in flight answers from the old contents, and later searches see the new ones.
- R9: Each request produces exactly one response pulse, one cycle wide, on the side that asked.
- R10: A commit changes only the entry at its index. Every index from 0 to 63 can be written and found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Register select (index, tag, data, command) |
| sw_wdata | input | 32 | Register write data |
| i_req | input | 1 | Instruction-side lookup request |
| i_vpn | input | 22 | Instruction-side virtual page number (1 KB units) |
| i_rsp | output | 1 | Instruction-side response pulse |
| i_hit | output | 1 | Instruction-side found flag |
| i_ppn | output | 22 | Instruction-side physical page number |
| i_size | output | 3 | Instruction-side size code |
| d_req | input | 1 | Data-side lookup request |
| d_vpn | input | 22 | Data-side virtual page number (1 KB units) |
| d_rsp | output | 1 | Data-side response pulse |
| d_hit | output | 1 | Data-side found flag |
| d_ppn | output | 22 | Data-side physical page number |
| d_size | output | 3 | Data-side size code |

## Verification
A sweep writes all 64 indices with distinct pages and looks each one up from alternating sides. This tells apart a wrong bank or row decode, a stale entry, and a latency that depends on where the match sits. A second sweep runs over all eight size codes and probes the first and last page inside each region and the first page just outside it. This separates a correct mask width from one that is off by one power of four. Directed patterns cover:
- overlapping entries, in the same row and in different rows, to expose a wrong priority;
- invalid-but-matching entries;
- requests from both sides in the same cycle;
- commits and flushes landing in the middle of a search, which show whether the in-flight answer and the following answer come from the right contents.

// File: rtl/pgtab_pkg.sv
package pgtab_pkg;
  typedef enum logic [1:0] {
    REG_INDEX = 2'd0,
    REG_TAG   = 2'd1,
    REG_DATA  = 2'd2,
    REG_CMD   = 2'd3
  } reg_sel_e;

  localparam int CMD_COMMIT_BIT = 0;
  localparam int CMD_FLUSH_BIT  = 1;
  localparam int SIDE_INSN      = 0;
  localparam int SIDE_DATA      = 1;
endpackage

// File: rtl/pgtab_bank.sv
module pgtab_bank #(
  parameter int DEPTH = 16,
  parameter int W     = 47,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  // Small distributed memory: one write port, asynchronous read.
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pgtab_regif.sv
module pgtab_regif
  import pgtab_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int IDX_W  = 6,
  parameter int VPN_W  = 22,
  parameter int PPN_W  = 22,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr,
  input  logic [1:0]        sw_sel,
  input  logic [REG_W-1:0]  sw_wdata,
  input  logic              table_free,
  output logic              op_go,
  output logic              op_flush,
  output logic [IDX_W-1:0]  op_idx,
  output logic [VPN_W-1:0]  op_vpn,
  output logic [SIZE_W-1:0] op_size,
  output logic [PPN_W-1:0]  op_ppn,
  output logic              op_valid
);
  localparam int OP_W = 1 + IDX_W + VPN_W + SIZE_W + PPN_W + 1;

  reg_sel_e sel;
  assign sel = reg_sel_e'(sw_sel);

  logic [IDX_W-1:0]  stg_idx;
  logic [VPN_W-1:0]  stg_vpn;
  logic [SIZE_W-1:0] stg_size;
  logic              stg_valid;
  logic [PPN_W-1:0]  stg_ppn;

  // Staging registers: written one word at a time by software.
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_idx   <= '0;
      stg_vpn   <= '0;
      stg_size  <= '0;
      stg_valid <= 1'b0;
      stg_ppn   <= '0;
    end else if (sw_wr) begin
      case (sel)
        REG_INDEX: stg_idx <= sw_wdata[IDX_W-1:0];
        REG_TAG: begin
          stg_vpn   <= sw_wdata[REG_W-1 -: VPN_W];
          stg_size  <= sw_wdata[SIZE_W:1];
          stg_valid <= sw_wdata[0];
        end
        REG_DATA: stg_ppn <= sw_wdata[REG_W-1 -: PPN_W];
        default: ;
      endcase
    end
  end

  logic            cmd_fire;
  logic [OP_W-1:0] new_op;
  logic [OP_W-1:0] cur_op;
  logic            hold_q;
  logic [OP_W-1:0] hold_op;

  assign cmd_fire = sw_wr && (sel == REG_CMD) &&
                    (sw_wdata[CMD_COMMIT_BIT] || sw_wdata[CMD_FLUSH_BIT]);
  assign new_op   = {sw_wdata[CMD_FLUSH_BIT], stg_idx, stg_vpn, stg_size, stg_ppn, stg_valid};

  // A held operation goes first; a fresh one goes straight through when the table is free.
  always_comb begin
    op_go  = 1'b0;
    cur_op = hold_op;
    if (table_free && hold_q) begin
      op_go  = 1'b1;
      cur_op = hold_op;
    end else if (table_free && cmd_fire) begin
      op_go  = 1'b1;
      cur_op = new_op;
    end
  end

  assign {op_flush, op_idx, op_vpn, op_size, op_ppn, op_valid} = cur_op;

  // One-deep hold buffer for commands that arrive during a search.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      hold_op <= '0;
    end else if (cmd_fire && (hold_q || !table_free)) begin
      hold_q  <= 1'b1;
      hold_op <= new_op;
    end else if (table_free) begin
      hold_q  <= 1'b0;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^sw_wdata;
endmodule

// File: rtl/pgtab_arb.sv
module pgtab_arb
  import pgtab_pkg::*;
#(
  parameter int VPN_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_req,
  input  logic [VPN_W-1:0] i_vpn,
  input  logic             d_req,
  input  logic [VPN_W-1:0] d_vpn,
  input  logic             table_free,
  output logic             start,
  output logic             start_side,
  output logic [VPN_W-1:0] start_vpn
);
  logic             pend_i, pend_d;
  logic [VPN_W-1:0] keep_i, keep_d;
  logic             want_i, want_d;
  logic [VPN_W-1:0] key_i, key_d;

  assign want_i = pend_i || i_req;
  assign want_d = pend_d || d_req;
  assign key_i  = pend_i ? keep_i : i_vpn;
  assign key_d  = pend_d ? keep_d : d_vpn;

  // Fixed priority: the instruction side wins a tie.
  assign start      = table_free && (want_i || want_d);
  assign start_side = want_i ? 1'(SIDE_INSN) : 1'(SIDE_DATA);
  assign start_vpn  = want_i ? key_i : key_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_i <= 1'b0;
      pend_d <= 1'b0;
      keep_i <= '0;
      keep_d <= '0;
    end else begin
      if (i_req && !pend_i) keep_i <= i_vpn;
      if (d_req && !pend_d) keep_d <= d_vpn;
      pend_i <= want_i && !(start && start_side == 1'(SIDE_INSN));
      pend_d <= want_d && !(start && start_side == 1'(SIDE_DATA));
    end
  end
endmodule

// File: rtl/pgtab_scan.sv
module pgtab_scan #(
  parameter int LANES  = 4,
  parameter int ROWS   = 16,
  parameter int VPN_W  = 22,
  parameter int PPN_W  = 22,
  parameter int SIZE_W = 3,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          start_side,
  input  logic [VPN_W-1:0]              start_vpn,
  input  logic [LANES-1:0]              row_valid,
  input  logic [LANES-1:0][VPN_W-1:0]   row_vpn,
  input  logic [LANES-1:0][SIZE_W-1:0]  row_size,
  input  logic [LANES-1:0][PPN_W-1:0]   row_ppn,
  output logic [ROW_W-1:0]              row_addr,
  output logic                          table_free,
  output logic                          scan_busy,
  output logic                          scan_last,
  output logic [1:0]                    rsp_v,
  output logic [1:0]                    rsp_hit,
  output logic [1:0][PPN_W-1:0]         rsp_ppn,
  output logic [1:0][SIZE_W-1:0]        rsp_size
);
  function automatic logic [VPN_W-1:0] page_mask(input logic [SIZE_W-1:0] sz);
    return {VPN_W{1'b1}} << {sz, 1'b0};
  endfunction

  logic              busy_q;
  logic [ROW_W-1:0]  ptr_q;
  logic              side_q;
  logic [VPN_W-1:0]  key_q;
  logic              found_q;
  logic [PPN_W-1:0]  acc_ppn;
  logic [SIZE_W-1:0] acc_size;

  logic [LANES-1:0]  lane_hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_hit[l] = row_valid[l] &&
                         (((row_vpn[l] ^ key_q) & page_mask(row_size[l])) == '0);
  end

  // Lowest lane of the row wins.
  logic              row_any;
  logic [PPN_W-1:0]  row_sel_ppn;
  logic [SIZE_W-1:0] row_sel_size;

  always_comb begin
    row_any      = 1'b0;
    row_sel_ppn  = '0;
    row_sel_size = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (lane_hit[l]) begin
        row_any      = 1'b1;
        row_sel_ppn  = row_ppn[l];
        row_sel_size = row_size[l];
      end
    end
  end

  logic              fin_hit;
  logic [PPN_W-1:0]  fin_ppn;
  logic [SIZE_W-1:0] fin_size;

  assign fin_hit  = found_q || row_any;
  assign fin_ppn  = found_q ? acc_ppn  : row_sel_ppn;
  assign fin_size = found_q ? acc_size : row_sel_size;

  assign scan_busy  = busy_q;
  assign scan_last  = busy_q && (ptr_q == ROW_W'(ROWS - 1));
  assign table_free = !busy_q || scan_last;
  assign row_addr   = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      ptr_q    <= '0;
      side_q   <= 1'b0;
      key_q    <= '0;
      found_q  <= 1'b0;
      acc_ppn  <= '0;
      acc_size <= '0;
      rsp_v    <= '0;
      rsp_hit  <= '0;
      rsp_ppn  <= '0;
      rsp_size <= '0;
    end else begin
      rsp_v <= '0;
      if (busy_q) begin
        ptr_q <= ptr_q + 1'b1;
        if (!found_q && row_any) begin
          found_q  <= 1'b1;
          acc_ppn  <= row_sel_ppn;
          acc_size <= row_sel_size;
        end
        if (scan_last) begin
          busy_q           <= 1'b0;
          rsp_v[side_q]    <= 1'b1;
          rsp_hit[side_q]  <= fin_hit;
          rsp_ppn[side_q]  <= fin_hit ? fin_ppn  : '0;
          rsp_size[side_q] <= fin_hit ? fin_size : '0;
        end
      end
      if (start) begin
        busy_q   <= 1'b1;
        ptr_q    <= '0;
        side_q   <= start_side;
        key_q    <= start_vpn;
        found_q  <= 1'b0;
        acc_ppn  <= '0;
        acc_size <= '0;
      end
    end
  end

  AST_RSP_AFTER_SCAN: assert property (@(posedge clk) disable iff (rst) (rsp_v != 2'b00) |-> $past(busy_q)) else $error("response without a search"); // R6
  AST_START_ON_FREE: assert property (@(posedge clk) disable iff (rst) start |-> table_free) else $error("search started while busy"); // R6
endmodule

// File: rtl/pgtab_store.sv
module pgtab_store #(
  parameter int ENTRIES = 64,
  parameter int LANES   = 4,
  parameter int VPN_W   = 22,
  parameter int PPN_W   = 22,
  parameter int SIZE_W  = 3,
  localparam int ROWS   = ENTRIES / LANES,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int LANE_W = $clog2(LANES),
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int EW     = VPN_W + SIZE_W + PPN_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          op_go,
  input  logic                          op_flush,
  input  logic [IDX_W-1:0]              op_idx,
  input  logic [VPN_W-1:0]              op_vpn,
  input  logic [SIZE_W-1:0]             op_size,
  input  logic [PPN_W-1:0]              op_ppn,
  input  logic                          op_valid,
  input  logic [ROW_W-1:0]              row_addr,
  output logic [LANES-1:0]              row_valid,
  output logic [LANES-1:0][VPN_W-1:0]   row_vpn,
  output logic [LANES-1:0][SIZE_W-1:0]  row_size,
  output logic [LANES-1:0][PPN_W-1:0]   row_ppn,
  output logic [ENTRIES-1:0]            valid_vec
);
  // Valid bits in flops so that a flush clears the table in one cycle.
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (op_go) begin
      if (op_flush) valid_q <= '0;
      else          valid_q[op_idx] <= op_valid;
    end
  end

  assign valid_vec = valid_q;

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    localparam logic [LANE_W-1:0] LID = LANE_W'(l);
    logic          we;
    logic [EW-1:0] rd;

    assign we = op_go && !op_flush && (op_idx[LANE_W-1:0] == LID);

    pgtab_bank #(.DEPTH(ROWS), .W(EW)) u_bank (
      .clk   (clk),
      .we    (we),
      .waddr (op_idx[IDX_W-1:LANE_W]),
      .wdata ({op_vpn, op_size, op_ppn}),
      .raddr (row_addr),
      .rdata (rd)
    );

    assign {row_vpn[l], row_size[l], row_ppn[l]} = rd;
    assign row_valid[l] = valid_q[{row_addr, LID}];
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) (op_go && op_flush) |=> (valid_q == '0)) else $error("flush left a valid entry"); // R7
endmodule

// File: rtl/pgtab_top.sv
module pgtab_top #(
  parameter int ENTRIES     = 64,
  parameter int LANES       = 4,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int MIN_PAGE_LG = 10,
  parameter int SIZE_W      = 3,
  parameter int REG_W       = 32,
  localparam int VPN_W      = VA_W - MIN_PAGE_LG,
  localparam int PPN_W      = PA_W - MIN_PAGE_LG,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int ROWS       = ENTRIES / LANES,
  localparam int ROW_W      = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr,
  input  logic [1:0]        sw_sel,
  input  logic [REG_W-1:0]  sw_wdata,
  input  logic              i_req,
  input  logic [VPN_W-1:0]  i_vpn,
  output logic              i_rsp,
  output logic              i_hit,
  output logic [PPN_W-1:0]  i_ppn,
  output logic [SIZE_W-1:0] i_size,
  input  logic              d_req,
  input  logic [VPN_W-1:0]  d_vpn,
  output logic              d_rsp,
  output logic              d_hit,
  output logic [PPN_W-1:0]  d_ppn,
  output logic [SIZE_W-1:0] d_size
);
  logic              table_free, scan_busy, scan_last;
  logic              op_go, op_flush, op_valid;
  logic [IDX_W-1:0]  op_idx;
  logic [VPN_W-1:0]  op_vpn;
  logic [SIZE_W-1:0] op_size;
  logic [PPN_W-1:0]  op_ppn;
  logic              start, start_side;
  logic [VPN_W-1:0]  start_vpn;
  logic [ROW_W-1:0]  row_addr;
  logic [LANES-1:0]             row_valid;
  logic [LANES-1:0][VPN_W-1:0]  row_vpn;
  logic [LANES-1:0][SIZE_W-1:0] row_size;
  logic [LANES-1:0][PPN_W-1:0]  row_ppn;
  logic [ENTRIES-1:0]           valid_vec;
  logic [1:0]                   rsp_v, rsp_hit;
  logic [1:0][PPN_W-1:0]        rsp_ppn;
  logic [1:0][SIZE_W-1:0]       rsp_size;

  pgtab_regif #(.REG_W(REG_W), .IDX_W(IDX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .SIZE_W(SIZE_W)) u_regif (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .table_free(table_free), .op_go(op_go), .op_flush(op_flush), .op_idx(op_idx),
    .op_vpn(op_vpn), .op_size(op_size), .op_ppn(op_ppn), .op_valid(op_valid)
  );

  pgtab_arb #(.VPN_W(VPN_W)) u_arb (
    .clk(clk), .rst(rst), .i_req(i_req), .i_vpn(i_vpn), .d_req(d_req), .d_vpn(d_vpn),
    .table_free(table_free), .start(start), .start_side(start_side), .start_vpn(start_vpn)
  );

  pgtab_store #(.ENTRIES(ENTRIES), .LANES(LANES), .VPN_W(VPN_W), .PPN_W(PPN_W), .SIZE_W(SIZE_W)) u_store (
    .clk(clk), .rst(rst), .op_go(op_go), .op_flush(op_flush), .op_idx(op_idx),
    .op_vpn(op_vpn), .op_size(op_size), .op_ppn(op_ppn), .op_valid(op_valid),
    .row_addr(row_addr), .row_valid(row_valid), .row_vpn(row_vpn),
    .row_size(row_size), .row_ppn(row_ppn), .valid_vec(valid_vec)
  );

  pgtab_scan #(.LANES(LANES), .ROWS(ROWS), .VPN_W(VPN_W), .PPN_W(PPN_W), .SIZE_W(SIZE_W)) u_scan (
    .clk(clk), .rst(rst), .start(start), .start_side(start_side), .start_vpn(start_vpn),
    .row_valid(row_valid), .row_vpn(row_vpn), .row_size(row_size), .row_ppn(row_ppn),
    .row_addr(row_addr), .table_free(table_free), .scan_busy(scan_busy), .scan_last(scan_last),
    .rsp_v(rsp_v), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_size(rsp_size)
  );

  assign i_rsp  = rsp_v[0];
  assign i_hit  = rsp_hit[0];
  assign i_ppn  = rsp_ppn[0];
  assign i_size = rsp_size[0];
  assign d_rsp  = rsp_v[1];
  assign d_hit  = rsp_hit[1];
  assign d_ppn  = rsp_ppn[1];
  assign d_size = rsp_size[1];

  AST_ONE_SIDE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst) !(i_rsp && d_rsp)) else $error("both sides answered together"); // R6
  AST_I_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) i_rsp |=> !i_rsp) else $error("instruction response wider than a cycle"); // R9
  AST_D_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) d_rsp |=> !d_rsp) else $error("data response wider than a cycle"); // R9
  AST_I_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst) (i_rsp && !i_hit) |-> (i_ppn == '0 && i_size == '0)) else $error("instruction miss carries data"); // R4
  AST_D_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst) (d_rsp && !d_hit) |-> (d_ppn == '0 && d_size == '0)) else $error("data miss carries data"); // R4
  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (rst) (scan_busy && !scan_last) |=> $stable(valid_vec)) else $error("table changed mid-search"); // R8
endmodule

// File: tb/pgtab_top_bench.sv
`timescale 1ns/1ps
module pgtab_top_bench;
  localparam int VW = 22;
  localparam int PW = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sw_wr = 1'b0;
  logic [1:0]    sw_sel = '0;
  logic [31:0]   sw_wdata = '0;
  logic          i_req = 1'b0, d_req = 1'b0;
  logic [VW-1:0] i_vpn = '0, d_vpn = '0;
  logic          i_rsp, i_hit, d_rsp, d_hit;
  logic [PW-1:0] i_ppn, d_ppn;
  logic [2:0]    i_size, d_size;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  pgtab_top u_pgtab_top (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .i_req(i_req), .i_vpn(i_vpn), .i_rsp(i_rsp), .i_hit(i_hit), .i_ppn(i_ppn), .i_size(i_size),
    .d_req(d_req), .d_vpn(d_vpn), .d_rsp(d_rsp), .d_hit(d_hit), .d_ppn(d_ppn), .d_size(d_size)
  );

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    sw_wr = 1'b1; sw_sel = sel; sw_wdata = data;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic put_entry(input int idx, input logic [VW-1:0] vpn, input logic [2:0] sz,
                           input logic [PW-1:0] ppn, input bit vld);
    reg_wr(2'd0, 32'(idx));
    reg_wr(2'd1, {vpn, 6'b0, sz, vld});
    reg_wr(2'd2, {ppn, 10'b0});
    reg_wr(2'd3, 32'h1);
  endtask

  task automatic flush_all();
    reg_wr(2'd3, 32'h2);
  endtask

  task automatic lookup(input int side, input logic [VW-1:0] vpn, input bit eh,
                        input logic [PW-1:0] ep, input logic [2:0] es, input int elat, input string rq);
    int cnt;
    bit seen;
    logic h;
    logic [PW-1:0] p;
    logic [2:0] s;
    @(negedge clk);
    if (side == 0) begin i_req = 1'b1; i_vpn = vpn; end
    else           begin d_req = 1'b1; d_vpn = vpn; end
    @(negedge clk);
    if (side == 0) i_req = 1'b0; else d_req = 1'b0;
    cnt = 0; seen = 1'b0;
    while (!seen && cnt < 80) begin
      if ((side == 0) ? i_rsp : d_rsp) seen = 1'b1;
      else begin @(negedge clk); cnt++; end
    end
    h = (side == 0) ? i_hit : d_hit;
    p = (side == 0) ? i_ppn : d_ppn;
    s = (side == 0) ? i_size : d_size;
    chk(seen, "R9", "response pulse seen", longint'(seen), 1);
    chk(cnt == elat, "R6", "latency in edges", cnt, elat);
    chk(h == eh, rq, "found flag", longint'(h), longint'(eh));
    chk(p == ep, rq, "physical page", longint'(p), longint'(ep));
    chk(s == es, rq, "size code", longint'(s), longint'(es));
    @(negedge clk);
    chk(((side == 0) ? i_rsp : d_rsp) == 1'b0, "R9", "pulse one cycle wide", 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R6 watchdog: run hung, cycles got %0d expected below %0d", 150000, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state and empty table
    chk(i_rsp == 1'b0 && d_rsp == 1'b0, "R1", "no pulse after reset", {i_rsp, d_rsp}, 0);
    chk(i_hit == 1'b0 && d_hit == 1'b0, "R1", "found flags low after reset", {i_hit, d_hit}, 0);
    lookup(0, '0, 1'b0, '0, '0, 16, "R1");
    lookup(1, 22'h3FFFFF, 1'b0, '0, '0, 16, "R1");

    // R2 / R10: every index written and found, alternating sides
    for (int k = 0; k < 64; k++)
      put_entry(k, VW'(32'h1000 + k * 37), 3'd0, PW'(k * 5 + 3), 1'b1);
    for (int k = 0; k < 64; k++)
      lookup(k % 2, VW'(32'h1000 + k * 37), 1'b1, PW'(k * 5 + 3), 3'd0, 16, "R10");
    lookup(0, 22'h3FFFFF, 1'b0, '0, '0, 16, "R2");

    // R10: rewriting one index leaves its neighbours untouched
    put_entry(17, VW'(32'h1000 + 17 * 37), 3'd0, 22'h2BEEF, 1'b1);
    lookup(1, VW'(32'h1000 + 17 * 37), 1'b1, 22'h2BEEF, 3'd0, 16, "R10");
    lookup(0, VW'(32'h1000 + 16 * 37), 1'b1, PW'(16 * 5 + 3), 3'd0, 16, "R10");
    lookup(1, VW'(32'h1000 + 18 * 37), 1'b1, PW'(18 * 5 + 3), 3'd0, 16, "R10");

    // R7: flush empties the table
    flush_all();
    for (int k = 0; k < 64; k += 9)
      lookup(k % 2, VW'(32'h1000 + k * 37), 1'b0, '0, '0, 16, "R7");

    // R3: every size code, first/last page inside and first page outside
    for (int s = 0; s < 8; s++) begin
      logic [VW-1:0] low, base;
      low  = VW'((32'h1 << (2 * s)) - 1);
      base = 22'h2AAAAA & ~low;
      flush_all();
      put_entry(21, base, 3'(s), PW'(32'h100 + s), 1'b1);
      lookup(s % 2, base, 1'b1, PW'(32'h100 + s), 3'(s), 16, "R3");
      lookup((s + 1) % 2, base | low, 1'b1, PW'(32'h100 + s), 3'(s), 16, "R3");
      lookup(s % 2, base ^ VW'(32'h1 << (2 * s)), 1'b0, '0, '0, 16, "R3");
      lookup((s + 1) % 2, base ^ VW'(32'h1 << 21), 1'b0, '0, '0, 16, "R3");
    end

    // R4: a matching entry with valid=0 never answers
    flush_all();
    put_entry(12, 22'h0777, 3'd0, 22'h0123, 1'b1);
    lookup(0, 22'h0777, 1'b1, 22'h0123, 3'd0, 16, "R4");
    put_entry(12, 22'h0777, 3'd0, 22'h0123, 1'b0);
    lookup(1, 22'h0777, 1'b0, '0, '0, 16, "R4");

    // R5: lowest index wins, across rows and inside one row
    flush_all();
    put_entry(40, 22'h3000, 3'd0, 22'h40, 1'b1);
    put_entry(9,  22'h3000, 3'd2, 22'h09, 1'b1);
    lookup(0, 22'h3000, 1'b1, 22'h09, 3'd2, 16, "R5");
    lookup(1, 22'h3001, 1'b1, 22'h09, 3'd2, 16, "R5");
    put_entry(3, 22'h5000, 3'd0, 22'h33, 1'b1);
    put_entry(2, 22'h5000, 3'd1, 22'h22, 1'b1);
    lookup(0, 22'h5000, 1'b1, 22'h22, 3'd1, 16, "R5");

    // R6: both sides on the same edge, instruction served first
    fork
      lookup(0, 22'h5000, 1'b1, 22'h22, 3'd1, 16, "R6");
      lookup(1, 22'h3000, 1'b1, 22'h09, 3'd2, 32, "R6");
    join

    // R8: commit landing mid-search is held; in-flight answer uses old contents
    flush_all();
    put_entry(63, 22'h0ABCD, 3'd0, 22'h111, 1'b1);
    fork
      lookup(1, 22'h0ABCD, 1'b1, 22'h111, 3'd0, 16, "R8");
      begin
        repeat (3) @(negedge clk);
        put_entry(63, 22'h0ABCD, 3'd0, 22'h222, 1'b1);
      end
    join
    lookup(0, 22'h0ABCD, 1'b1, 22'h222, 3'd0, 16, "R8");

    // R8 / R7: flush landing mid-search
    fork
      lookup(0, 22'h0ABCD, 1'b1, 22'h222, 3'd0, 16, "R8");
      begin
        repeat (5) @(negedge clk);
        flush_all();
      end
    join
    lookup(1, 22'h0ABCD, 1'b0, '0, '0, 16, "R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule